// File: doc/BRIEF.md
# Fault Escalation and Lockup Unit

This unit sits beside a processor core and decides, for each fault or supervisor-call event, which exception the core should take. Usage, memory-management and bus faults each carry a programmable urgency level and an enable flag. A fault is delivered as its own exception only when it is enabled and strictly more urgent than the priority the core is running at. Otherwise it is promoted to a hard fault. Hard fault has a fixed level of -1, above every programmable value. A hard fault that arises while the core is already at that level parks the unit in a lockup state. Only reset, a non-maskable interrupt or a debug halt request ends that state.

Alongside the arbitration, the unit keeps a sticky 32-bit fault status word and two fault address registers, a memory-management one and a bus one. Each address register is guarded by a validity flag inside the status word. Software reads and writes all registers through a small synchronous register port. Read data appears one cycle after the address.

The core presents its current execution priority as a signed value. The levels are:
- -1: hard-fault handler active.
- 0 to 255: programmable exception levels; a lower number is more urgent.
- 256: thread level.

The unit answers with a registered one-cycle `take_exc` pulse, a 4-bit exception number and a level `lockup` output.

Top module: `fault_escalator`

## Requirements
- R1: After reset `take_exc`, `exc_num` and `lockup` are 0, and every register (offsets 0, 4, 8, 12, 16) reads as 0.
- R2: A fault event is classed by `fault_cause`:
  - Cause 0 (undefined instruction) and cause 1 (unaligned access) are usage faults, exception 6.
  - Cause 2 (access violation) is a memory-management fault, exception 4.
  - Cause 3 (bus error) is a bus fault, exception 5.

  The class's exception is taken when its enable bit is 1 and its level is strictly below `cur_pri`. The result appears as a one-cycle `take_exc` pulse with `exc_num` in the cycle after the event. `exc_num` is 0 whenever `take_exc` is 0.
- R3: A fault whose class is disabled, or whose level is greater than or equal to `cur_pri`, is taken as hard fault, exception 3, provided `cur_pri` is not -1.
- R4: A supervisor call is handled by comparing the supervisor-call level with `cur_pri`:
  - Level below `cur_pri`: exception 11 is taken.
  - Otherwise, with `cur_pri` not -1: status bit 17 is set and the request follows the usage-fault rule of R2 and R3.
  - Otherwise, with `cur_pri` at -1: the request becomes a hard fault.

  A fault event in the same cycle takes precedence, and the supervisor call is dropped.
- R5: A hard fault arising while `cur_pri` is -1 raises `lockup` in the next cycle instead of a `take_exc` pulse.
- R6: Once raised, `lockup` stays 1 until reset, `nmi_req` or `dbg_halt` is seen. Fault and supervisor-call events presented while locked produce no pulse and leave the status word unchanged.
- R7: The status word at offset 0 has these sticky bits:

  | Bit | Set by |
  |-----|--------|
  | 0 | access violation |
  | 8 | precise bus error |
  | 10 | imprecise bus error |
  | 16 | undefined instruction |
  | 24 | unaligned access |

  Status bits are recorded even when the fault is promoted. Writing 1 to a bit at offset 0 clears it. A bit that is set and cleared in the same cycle ends up set.
- R8: A memory-management fault loads `fault_addr` into offset 12 and sets bit 7. A precise bus fault loads it into offset 16 and sets bit 15. Neither load happens while the matching valid bit is already set. An imprecise bus fault (`fault_imprecise`=1) loads no address.
- R9: Offset 4 holds the levels as `{svc[31:24], bus[23:16], mm[15:8], usage[7:0]}`. Offset 8 holds the enables in bit 0 (usage), bit 1 (mm) and bit 2 (bus). Both read back what was written. Writes to offsets 12 and 16 are ignored. Offsets 4 and 8 reset to 0, so after reset every fault is promoted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_valid | input | 1 | A fault event is presented this cycle |
| fault_cause | input | 2 | Fault cause code (see R2) |
| fault_imprecise | input | 1 | Bus error was reported after buffered writes drained |
| fault_addr | input | 32 | Address associated with the fault |
| svc_req | input | 1 | Supervisor-call request |
| cur_pri | input | 10 | Signed current execution priority (-1 to 256) |
| nmi_req | input | 1 | Non-maskable interrupt, releases lockup |
| dbg_halt | input | 1 | Debug halt request, releases lockup |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_addr` |
| take_exc | output | 1 | One-cycle pulse: take exception `exc_num` |
| exc_num | output | 4 | Exception number to take |
| lockup | output | 1 | Core is locked up |

## Verification
The urgency comparison is driven at the points where it changes outcome:
- Current priority one above, equal to and one below a class level, which separates a strict comparison from an inclusive one.
- Thread level and the hard-fault level, which separate promotion from lockup.

Supervisor calls are tried above, at and below their own level, so the usage-fault path and its status bit are told apart from a direct hard fault. Repeated faults with valid bits set or cleared separate address capture from address holding, and same-cycle set-and-clear writes show which wins. Constrained random traffic then mixes causes, enables, levels and release requests against a bench model.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;
  // exception numbers
  localparam logic [3:0] EXC_NONE  = 4'd0;
  localparam logic [3:0] EXC_HARD  = 4'd3;
  localparam logic [3:0] EXC_MEM   = 4'd4;
  localparam logic [3:0] EXC_BUS   = 4'd5;
  localparam logic [3:0] EXC_USAGE = 4'd6;
  localparam logic [3:0] EXC_SVC   = 4'd11;

  // fault cause codes
  typedef enum logic [1:0] {
    CAUSE_UNDEF   = 2'd0,
    CAUSE_UNALIGN = 2'd1,
    CAUSE_ACCESS  = 2'd2,
    CAUSE_BUSERR  = 2'd3
  } cause_e;

  // configurable class index into the level / enable fields
  localparam int CLS_USAGE = 0;
  localparam int CLS_MEM   = 1;
  localparam int CLS_BUS   = 2;
  localparam int CLS_SVC   = 3;
  localparam int NUM_LVL   = 4;
  localparam int NUM_EN    = 3;

  // status word bit positions
  localparam int ST_ACCESS  = 0;
  localparam int ST_MVALID  = 7;
  localparam int ST_PRECISE = 8;
  localparam int ST_IMPREC  = 10;
  localparam int ST_BVALID  = 15;
  localparam int ST_UNDEF   = 16;
  localparam int ST_INVPRE  = 17;
  localparam int ST_UNALIGN = 24;

  // register byte offsets
  localparam logic [4:0] OFS_STATUS = 5'd0;
  localparam logic [4:0] OFS_LEVELS = 5'd4;
  localparam logic [4:0] OFS_ENABLE = 5'd8;
  localparam logic [4:0] OFS_MADDR  = 5'd12;
  localparam logic [4:0] OFS_BADDR  = 5'd16;
endpackage

// File: rtl/fault_esc_arbiter.sv
module fault_esc_arbiter
  import fault_esc_pkg::*;
#(
  parameter int PW = 8,
  parameter int DW = 32,
  localparam int CW = PW + 2
) (
  input  logic                      ev_fault,
  input  logic [1:0]                ev_cause,
  input  logic                      ev_imprecise,
  input  logic                      ev_svc,
  input  logic signed [CW-1:0]      cur_pri,
  input  logic [NUM_LVL-1:0][PW-1:0] lvl,
  input  logic [NUM_EN-1:0]         en,
  output logic                      take_d,
  output logic [3:0]                num_d,
  output logic                      lock_d,
  output logic [DW-1:0]             set_d,
  output logic                      mcap_d,
  output logic                      bcap_d
);
  localparam logic signed [CW-1:0] HARD_LVL = '1;

  logic cur_is_hard;
  logic [NUM_LVL-1:0] beats;   // level strictly more urgent than cur_pri
  logic hard_needed;
  logic cls_ok;
  logic [3:0] cls_num;

  assign cur_is_hard = (cur_pri == HARD_LVL);

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_cmp
    assign beats[k] = ($signed({2'b00, lvl[k]}) < cur_pri);
  end

  always_comb begin
    take_d      = 1'b0;
    num_d       = EXC_NONE;
    lock_d      = 1'b0;
    set_d       = '0;
    mcap_d      = 1'b0;
    bcap_d      = 1'b0;
    hard_needed = 1'b0;
    cls_ok      = 1'b0;
    cls_num     = EXC_NONE;
    if (ev_fault) begin
      unique case (cause_e'(ev_cause))
        CAUSE_UNDEF: begin
          set_d[ST_UNDEF] = 1'b1;
          cls_ok  = en[CLS_USAGE] && beats[CLS_USAGE];
          cls_num = EXC_USAGE;
        end
        CAUSE_UNALIGN: begin
          set_d[ST_UNALIGN] = 1'b1;
          cls_ok  = en[CLS_USAGE] && beats[CLS_USAGE];
          cls_num = EXC_USAGE;
        end
        CAUSE_ACCESS: begin
          set_d[ST_ACCESS] = 1'b1;
          mcap_d  = 1'b1;
          cls_ok  = en[CLS_MEM] && beats[CLS_MEM];
          cls_num = EXC_MEM;
        end
        default: begin
          if (ev_imprecise) set_d[ST_IMPREC] = 1'b1;
          else begin
            set_d[ST_PRECISE] = 1'b1;
            bcap_d = 1'b1;
          end
          cls_ok  = en[CLS_BUS] && beats[CLS_BUS];
          cls_num = EXC_BUS;
        end
      endcase
      if (cls_ok) begin
        take_d = 1'b1;
        num_d  = cls_num;
      end else begin
        hard_needed = 1'b1;
      end
    end else if (ev_svc) begin
      if (beats[CLS_SVC]) begin
        take_d = 1'b1;
        num_d  = EXC_SVC;
      end else if (cur_is_hard) begin
        hard_needed = 1'b1;
      end else begin
        set_d[ST_INVPRE] = 1'b1;
        if (en[CLS_USAGE] && beats[CLS_USAGE]) begin
          take_d = 1'b1;
          num_d  = EXC_USAGE;
        end else begin
          hard_needed = 1'b1;
        end
      end
    end
    if (hard_needed) begin
      if (cur_is_hard) lock_d = 1'b1;
      else begin
        take_d = 1'b1;
        num_d  = EXC_HARD;
      end
    end
  end

  // R5: a decision is either a delivered exception or a lockup, never both
  always_comb begin
    a_r5_take_or_lock: assert (!(take_d && lock_d));
  end
endmodule

// File: rtl/fault_esc_regs.sv
module fault_esc_regs
  import fault_esc_pkg::*;
#(
  parameter int PW = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int LVL_BITS = NUM_LVL * PW
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [4:0]                 addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  input  logic [DW-1:0]              set_bits,
  input  logic                       mcap,
  input  logic                       bcap,
  input  logic [AW-1:0]              cap_addr,
  output logic [NUM_LVL-1:0][PW-1:0] lvl,
  output logic [NUM_EN-1:0]          en
);
  logic [DW-1:0] stat_q;
  logic [AW-1:0] maddr_q, baddr_q;
  logic [NUM_LVL-1:0][PW-1:0] lvl_q;
  logic [NUM_EN-1:0] en_q;
  logic [DW-1:0] clr, set_all, lvl_word;
  logic mtake, btake;

  assign mtake = mcap && !stat_q[ST_MVALID];
  assign btake = bcap && !stat_q[ST_BVALID];
  assign clr   = (we && addr == OFS_STATUS) ? wdata : '0;

  always_comb begin
    set_all = set_bits;
    set_all[ST_MVALID] = set_bits[ST_MVALID] | mtake;
    set_all[ST_BVALID] = set_bits[ST_BVALID] | btake;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      maddr_q <= '0;
      baddr_q <= '0;
      lvl_q   <= '0;
      en_q    <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | set_all;
      if (mtake) maddr_q <= cap_addr;
      if (btake) baddr_q <= cap_addr;
      if (we && addr == OFS_LEVELS) begin
        for (int k = 0; k < NUM_LVL; k++) lvl_q[k] <= wdata[k*PW +: PW];
      end
      if (we && addr == OFS_ENABLE) en_q <= wdata[NUM_EN-1:0];
    end
  end

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_pack
    assign lvl_word[k*PW +: PW] = lvl_q[k];
  end
  if (LVL_BITS < DW) begin : g_pad
    assign lvl_word[DW-1:LVL_BITS] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (addr)
        OFS_STATUS: rdata <= stat_q;
        OFS_LEVELS: rdata <= lvl_word;
        OFS_ENABLE: rdata <= DW'(en_q);
        OFS_MADDR:  rdata <= DW'(maddr_q);
        OFS_BADDR:  rdata <= DW'(baddr_q);
        default:    rdata <= '0;
      endcase
    end
  end

  assign lvl = lvl_q;
  assign en  = en_q;

  // R8: a held address does not move while its valid flag is set
  a_r8_maddr_hold: assert property (@(posedge clk) disable iff (rst)
    stat_q[ST_MVALID] |=> $stable(maddr_q));
  a_r8_baddr_hold: assert property (@(posedge clk) disable iff (rst)
    stat_q[ST_BVALID] |=> $stable(baddr_q));
  // R7: a status bit stays set unless a 1 is written to it
  a_r7_undef_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat_q[ST_UNDEF] && !(we && addr == OFS_STATUS && wdata[ST_UNDEF]))
      |=> stat_q[ST_UNDEF]);
endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
  import fault_esc_pkg::*;
#(
  parameter int PW = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int CW = PW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fault_valid,
  input  logic [1:0]           fault_cause,
  input  logic                 fault_imprecise,
  input  logic [AW-1:0]        fault_addr,
  input  logic                 svc_req,
  input  logic signed [CW-1:0] cur_pri,
  input  logic                 nmi_req,
  input  logic                 dbg_halt,
  input  logic                 reg_we,
  input  logic [4:0]           reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 take_exc,
  output logic [3:0]           exc_num,
  output logic                 lockup
);
  localparam logic signed [CW-1:0] HARD_LVL = '1;

  logic [NUM_LVL-1:0][PW-1:0] lvl;
  logic [NUM_EN-1:0] en;
  logic take_d, lock_d, mcap_d, bcap_d;
  logic [3:0] num_d;
  logic [DW-1:0] set_d;
  logic ev_fault, ev_svc;

  // events are dropped entirely while locked
  assign ev_fault = fault_valid && !lockup;
  assign ev_svc   = svc_req && !lockup;

  fault_esc_arbiter #(.PW(PW), .DW(DW)) u_arb (
    .ev_fault     (ev_fault),
    .ev_cause     (fault_cause),
    .ev_imprecise (fault_imprecise),
    .ev_svc       (ev_svc),
    .cur_pri      (cur_pri),
    .lvl          (lvl),
    .en           (en),
    .take_d       (take_d),
    .num_d        (num_d),
    .lock_d       (lock_d),
    .set_d        (set_d),
    .mcap_d       (mcap_d),
    .bcap_d       (bcap_d)
  );

  fault_esc_regs #(.PW(PW), .AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .set_bits (set_d),
    .mcap     (mcap_d),
    .bcap     (bcap_d),
    .cap_addr (fault_addr),
    .lvl      (lvl),
    .en       (en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_exc <= 1'b0;
      exc_num  <= EXC_NONE;
      lockup   <= 1'b0;
    end else begin
      take_exc <= take_d;
      exc_num  <= take_d ? num_d : EXC_NONE;
      if (lockup) lockup <= !(nmi_req || dbg_halt);
      else        lockup <= lock_d;
    end
  end

  // R6: lockup persists until a release request
  a_r6_lock_hold: assert property (@(posedge clk) disable iff (rst)
    (lockup && !nmi_req && !dbg_halt) |=> lockup);
  // R6: no exception is delivered from the locked state
  a_r6_no_pulse_locked: assert property (@(posedge clk) disable iff (rst)
    lockup |=> !take_exc);
  // R5: lockup can only begin from the hard-fault level
  a_r5_lock_entry: assert property (@(posedge clk) disable iff (rst)
    (!lockup && cur_pri != HARD_LVL) |=> !lockup);
  // R2: only legal exception numbers are delivered
  a_r2_num_legal: assert property (@(posedge clk) disable iff (rst)
    take_exc |-> (exc_num == EXC_HARD || exc_num == EXC_MEM || exc_num == EXC_BUS
                  || exc_num == EXC_USAGE || exc_num == EXC_SVC));
endmodule

// File: tb/sim_fault_escalator.sv
module sim_fault_escalator;
  logic clk = 1'b0;
  logic rst;
  logic fault_valid, fault_imprecise, svc_req, nmi_req, dbg_halt, reg_we;
  logic [1:0] fault_cause;
  logic [31:0] fault_addr, reg_wdata, reg_rdata;
  logic signed [9:0] cur_pri;
  logic [4:0] reg_addr;
  logic take_exc, lockup;
  logic [3:0] exc_num;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_stat, m_maddr, m_baddr;
  logic [7:0] m_lvl [4];
  logic [2:0] m_en;
  logic m_lock;

  always #5 clk = ~clk;

  fault_escalator u0 (
    .clk(clk), .rst(rst), .fault_valid(fault_valid), .fault_cause(fault_cause),
    .fault_imprecise(fault_imprecise), .fault_addr(fault_addr), .svc_req(svc_req),
    .cur_pri(cur_pri), .nmi_req(nmi_req), .dbg_halt(dbg_halt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .take_exc(take_exc), .exc_num(exc_num), .lockup(lockup));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fault_valid = 0; fault_cause = 0; fault_imprecise = 0; fault_addr = 0;
    svc_req = 0; nmi_req = 0; dbg_halt = 0; reg_we = 0; reg_wdata = 0;
    reg_addr = 0; cur_pri = 10'sd256;
  endtask

  function automatic logic [31:0] rd_exp(logic [4:0] a);
    case (a)
      5'd0:  return m_stat;
      5'd4:  return {m_lvl[3], m_lvl[2], m_lvl[1], m_lvl[0]};
      5'd8:  return {29'd0, m_en};
      5'd12: return m_maddr;
      5'd16: return m_baddr;
      default: return 32'd0;
    endcase
  endfunction

  // expected outputs after the coming edge; advances the model
  task automatic model(output logic et, output logic [3:0] en_o, output logic el);
    logic hard, ok, cm, cb;
    logic [31:0] setb, clr;
    int cls;
    et = 0; en_o = 0; hard = 0; setb = 0; cm = 0; cb = 0; cls = 0; ok = 0;
    el = 0;
    if (!m_lock) begin
      if (fault_valid) begin
        case (fault_cause)
          2'd0: begin setb[16] = 1; cls = 0; end
          2'd1: begin setb[24] = 1; cls = 0; end
          2'd2: begin setb[0] = 1; cls = 1; cm = 1; end
          default: begin
            cls = 2;
            if (fault_imprecise) setb[10] = 1;
            else begin setb[8] = 1; cb = 1; end
          end
        endcase
        ok = m_en[cls] && (int'(m_lvl[cls]) < int'(cur_pri));
        if (ok) begin et = 1; en_o = (cls == 0) ? 4'd6 : (cls == 1) ? 4'd4 : 4'd5; end
        else hard = 1;
      end else if (svc_req) begin
        if (int'(m_lvl[3]) < int'(cur_pri)) begin et = 1; en_o = 4'd11; end
        else if (cur_pri == -10'sd1) hard = 1;
        else begin
          setb[17] = 1;
          if (m_en[0] && int'(m_lvl[0]) < int'(cur_pri)) begin et = 1; en_o = 4'd6; end
          else hard = 1;
        end
      end
      if (hard) begin
        if (cur_pri == -10'sd1) el = 1;
        else begin et = 1; en_o = 4'd3; end
      end
    end else el = !(nmi_req || dbg_halt);
    clr = (reg_we && reg_addr == 5'd0) ? reg_wdata : 32'd0;
    if (cm && !m_stat[7]) begin m_maddr = fault_addr; setb[7] = 1; end
    if (cb && !m_stat[15]) begin m_baddr = fault_addr; setb[15] = 1; end
    m_stat = (m_stat & ~clr) | setb;
    if (reg_we && reg_addr == 5'd4)
      for (int k = 0; k < 4; k++) m_lvl[k] = reg_wdata[k*8 +: 8];
    if (reg_we && reg_addr == 5'd8) m_en = reg_wdata[2:0];
    m_lock = el;
  endtask

  // one cycle: inputs already driven after a negedge
  task automatic step(string req);
    logic et, el;
    logic [3:0] en_o;
    logic [31:0] rexp;
    rexp = rd_exp(reg_addr);
    model(et, en_o, el);
    @(posedge clk); #1;
    chk(req, {31'd0, take_exc}, {31'd0, et});
    chk(req, {28'd0, exc_num}, {28'd0, en_o});
    chk(req, {31'd0, lockup}, {31'd0, el});
    if (!reg_we) chk(req, reg_rdata, rexp);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1;
    m_stat = 0; m_maddr = 0; m_baddr = 0; m_en = 0; m_lock = 0;
    for (int k = 0; k < 4; k++) m_lvl[k] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic fault(logic [1:0] c, logic imp, logic [31:0] a, logic signed [9:0] p);
    fault_valid = 1; fault_cause = c; fault_imprecise = imp; fault_addr = a; cur_pri = p;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd(string req, logic [4:0] a);
    reg_addr = a; step(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state and registers
    chk("R1", {30'd0, take_exc, lockup}, 32'd0);
    for (int a = 0; a <= 16; a += 4) rd("R1", 5'(a));
    // R3: disabled classes promote
    fault(2'd0, 0, 32'h0, 10'sd256); step("R3");
    rd("R7", 5'd0);
    // R9: configuration
    wr(5'd4, 32'h40302010); step("R9");
    wr(5'd8, 32'hFFFF_FFFF); step("R9");
    rd("R9", 5'd4); rd("R9", 5'd8);
    wr(5'd12, 32'hDEAD_BEEF); step("R9"); rd("R9", 5'd12);
    // R2 / R8: memory fault captured
    fault(2'd2, 0, 32'h0000_1000, 10'sd256); step("R2");
    rd("R8", 5'd12); rd("R8", 5'd0);
    fault(2'd2, 0, 32'h0000_2000, 10'sd33); step("R2");
    rd("R8", 5'd12);
    // R3: equal level promotes; precise bus address captured
    fault(2'd3, 0, 32'h0000_3000, 10'sd48); step("R3");
    rd("R8", 5'd16);
    fault(2'd3, 1, 32'h0000_4000, 10'sd49); step("R2");
    rd("R8", 5'd16); rd("R7", 5'd0);
    fault(2'd1, 0, 32'h0, 10'sd17); step("R2");
    fault(2'd1, 0, 32'h0, 10'sd16); step("R3");
    // R4: supervisor call paths
    svc_req = 1; cur_pri = 10'sd65; step("R4");
    svc_req = 1; cur_pri = 10'sd64; step("R4");
    rd("R4", 5'd0);
    svc_req = 1; cur_pri = 10'sd16; step("R4");
    fault(2'd2, 0, 32'h0, 10'sd256); svc_req = 1; step("R4");
    // R7: write-one-to-clear, then set wins over clear
    wr(5'd0, 32'h0000_0080); step("R7"); rd("R7", 5'd0);
    fault(2'd2, 0, 32'h0000_5000, 10'sd256); wr(5'd0, 32'h0000_0081); step("R7");
    rd("R7", 5'd0); rd("R8", 5'd12);
    // R5 / R6: lockup and release
    fault(2'd0, 0, 32'h0, -10'sd1); step("R5");
    fault(2'd1, 0, 32'h0, 10'sd256); step("R6");
    svc_req = 1; cur_pri = 10'sd256; step("R6");
    rd("R6", 5'd0); step("R6");
    nmi_req = 1; step("R6"); step("R6");
    svc_req = 1; cur_pri = -10'sd1; step("R5");
    dbg_halt = 1; step("R6");
    fault(2'd3, 0, 32'h0, -10'sd1); step("R5");
    do_reset();
    chk("R1", {31'd0, lockup}, 32'd0);
    rd("R1", 5'd0);
    // random traffic
    wr(5'd8, 32'h7); step("R9");
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r < 9) begin
        fault_valid = 1;
        fault_cause = 2'($urandom_range(0, 3));
        fault_imprecise = 1'($urandom_range(0, 1));
        fault_addr = $urandom;
      end
      svc_req = ($urandom_range(0, 3) == 0);
      r = $urandom_range(0, 9);
      cur_pri = (r == 0) ? -10'sd1 : (r == 1) ? 10'sd256 : 10'($urandom_range(0, 255));
      nmi_req = ($urandom_range(0, 7) == 0);
      dbg_halt = ($urandom_range(0, 15) == 0);
      r = $urandom_range(0, 11);
      if (r == 0) wr(5'd0, $urandom);
      else if (r == 1) wr(5'd4, $urandom);
      else if (r == 2) wr(5'd8, $urandom);
      else reg_addr = 5'($urandom_range(0, 4) * 4);
      step("R2");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    process p;
    p = process::self();
    p.srandom(32'h5eed_1234);
  end
endmodule